// File: doc/BRIEF.md
# DC Balance Block-Inversion Codec

This block keeps a serial frame free of long-term DC drift. On transmit, bits that arrive after the start-of-frame delimiter are gathered into 16-bit blocks. Each block is sent either true or inverted, and one marker bit goes ahead of the block to tell the receiver which. The choice follows a signed running disparity: a block whose own imbalance leans the same way as the running total is inverted. On receive, the block takes the same coded stream, reads each marker, drops it, and restores the 16 data bits before they go on to later stages.

Transmit coding and receive decoding each have their own enable. The start of coding is shared by both directions. Coding can begin with the first bit after the delimiter, or after a programmable number of byte times. The enables and the start settings are captured when the delimiter pulse arrives. Outside a frame, and in any frame whose direction is disabled, bits pass through unchanged. Each direction has one output register.

Top module: `dcb_codec`

## Requirements
- R1: After reset, `tx_out_valid` and `rx_out_valid` are low and `tx_in_ready` is high.
- R2: When transmit coding is off, or when no frame is open, each accepted transmit bit appears unchanged on `tx_out_bit` with `tx_out_valid` high, one cycle after acceptance.
- R3: A coded transmit block is one marker bit followed by its 16 data bits in arrival order. A marker of 1 means every data bit is inverted, and a marker of 0 means the bits are sent true.
- R4: The running disparity is cleared at `tx_sfd`. A full block has disparity 2*ones-16. The block is inverted exactly when both the running value and its own disparity are nonzero and have the same sign. The running value then adds the disparity of the block as sent, and its magnitude never exceeds 16.
- R5: A final block of 1 to 15 bits, closed by `tx_in_last`, is sent with marker 0 and its bits true. A final block of exactly 16 bits follows R4.
- R6: No transmit bit is lost or duplicated. A coded frame of k full blocks produces 17k output bits. While bits are offered back to back, `tx_in_ready` is low for exactly one cycle between consecutive coded blocks.
- R7: `start_dly_en`, `start_bytes`, `tx_code_en` and `rx_code_en` are sampled at the delimiter pulse. With `start_dly_en`=0, coding starts with the first bit after the delimiter. With `start_dly_en`=1, the first 8*`start_bytes` bits pass uncoded, and `start_bytes`=0 then means an immediate start.
- R8: With receive decoding on, the receiver drops each marker bit. It outputs each following data bit XOR the marker one cycle after that bit arrives, using the same start rule as transmit, so that a looped-back frame is recovered exactly.
- R9: With receive decoding off, each receive bit appears unchanged on `rx_out_bit` one cycle after it arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_code_en | input | 1 | Transmit coding enable, sampled at `tx_sfd` |
| rx_code_en | input | 1 | Receive decoding enable, sampled at `rx_sfd` |
| start_dly_en | input | 1 | 1 selects a delayed coding start |
| start_bytes | input | 4 | Delay before coding starts, in byte times |
| tx_sfd | input | 1 | Transmit delimiter pulse; opens a frame |
| tx_in_valid | input | 1 | Transmit input bit valid |
| tx_in_bit | input | 1 | Transmit input bit |
| tx_in_last | input | 1 | Marks the last bit of the transmit frame |
| tx_in_ready | output | 1 | Transmit input bit is taken this cycle |
| tx_out_valid | output | 1 | Line bit valid |
| tx_out_bit | output | 1 | Line bit |
| rx_sfd | input | 1 | Receive delimiter pulse; opens a frame |
| rx_in_valid | input | 1 | Receive line bit valid |
| rx_in_bit | input | 1 | Receive line bit |
| rx_in_last | input | 1 | Marks the last line bit of the receive frame |
| rx_out_valid | output | 1 | Decoded bit valid |
| rx_out_bit | output | 1 | Decoded bit |

## Verification
A pass-through bit is due on the output one cycle after it is accepted. A coded block's marker is due two cycles after its 16th bit is taken, or two cycles after the closing bit of a partial block, and its data bits follow on consecutive cycles. A decoded receive bit is due one cycle after it arrives. Inputs are driven and `tx_in_ready` is read on falling edges, which is also where outputs are captured. The captured streams are compared bit for bit with a stream built in the bench from the coding rules, so every expected bit is checked at the position where it is due. Marker positions, stall counts and stream lengths are checked at the indices that these latencies give.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    localparam int BLK_DEF = 16;
    localparam int OFS_W_DEF = 4;
    localparam int RD_W_DEF = 8;

    typedef struct packed {
        logic valid;
        logic data;
    } sbit_t;

    // Inversion decision: both nonzero and of the same sign.
    function automatic logic invert_rule(input int running, input int blk);
        return (running != 0) && (blk != 0) && ((running < 0) == (blk < 0));
    endfunction

endpackage

// File: rtl/dcb_start_gate.sv
module dcb_start_gate #(
    parameter int OFS_W = dcb_pkg::OFS_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sfd,
    input  logic             code_en,
    input  logic             dly_en,
    input  logic [OFS_W-1:0] ofs_bytes,
    input  logic             bit_taken,
    input  logic             bit_last,
    output logic             coding
);
    localparam int CW = OFS_W + 3;

    logic          in_frame;
    logic          en_q;
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            en_q     <= 1'b0;
            remain   <= '0;
        end else if (sfd) begin
            in_frame <= 1'b1;
            en_q     <= code_en;
            remain   <= dly_en ? {ofs_bytes, 3'b000} : '0;
        end else if (bit_taken && in_frame) begin
            if (bit_last) begin
                in_frame <= 1'b0;
            end else if (remain != '0) begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign coding = in_frame && en_q && (remain == '0);

endmodule

// File: rtl/dcb_tx_enc.sv
module dcb_tx_enc
    import dcb_pkg::*;
#(
    parameter int BLK  = BLK_DEF,
    parameter int RD_W = RD_W_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sfd,
    input  logic  coding,
    input  logic  in_valid,
    input  logic  in_bit,
    input  logic  in_last,
    output logic  in_ready,
    output logic  taken,
    output sbit_t out_q
);
    localparam int CW = $clog2(BLK + 1);
    localparam int IW = $clog2(BLK);

    logic [BLK-1:0]         col_buf, snd_buf;
    logic [CW-1:0]          col_cnt, snd_cnt, snd_slot, ones;
    logic                   flush_pend, snd_busy, snd_inv;
    logic signed [RD_W-1:0] rd;
    logic                   col_full, snd_free, xfer, do_inv;
    int                     disp_i;
    sbit_t                  emit;

    assign col_full = (col_cnt == CW'(BLK));
    assign snd_free = !snd_busy || (snd_slot == snd_cnt);
    assign xfer     = snd_free && (col_full || flush_pend);

    // Coded path stalls only while the collector is full; bypass waits for a drained pipe.
    assign in_ready = coding ? (!col_full && !flush_pend)
                             : (!snd_busy && !flush_pend && (col_cnt == '0));
    assign taken    = in_valid && in_ready;

    always_comb begin
        ones = '0;
        for (int i = 0; i < BLK; i++) begin
            ones = ones + CW'(col_buf[i]);
        end
        disp_i = 2 * int'(ones) - BLK;
        do_inv = col_full && invert_rule(int'(rd), disp_i);
    end

    always_comb begin
        emit = '0;
        if (snd_busy) begin
            emit.valid = 1'b1;
            emit.data  = (snd_slot == '0) ? snd_inv
                                          : (snd_buf[IW'(snd_slot - 1'b1)] ^ snd_inv);
        end else if (taken && !coding) begin
            emit.valid = 1'b1;
            emit.data  = in_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q      <= '0;
            col_buf    <= '0;
            snd_buf    <= '0;
            col_cnt    <= '0;
            snd_cnt    <= '0;
            snd_slot   <= '0;
            flush_pend <= 1'b0;
            snd_busy   <= 1'b0;
            snd_inv    <= 1'b0;
            rd         <= '0;
        end else begin
            out_q <= emit;
            if (taken && coding) begin
                col_buf[col_cnt[IW-1:0]] <= in_bit;
                col_cnt                  <= col_cnt + 1'b1;
                if (in_last) flush_pend <= 1'b1;
            end
            if (xfer) begin
                snd_buf    <= col_buf;
                snd_cnt    <= col_cnt;
                snd_inv    <= do_inv;
                snd_slot   <= '0;
                snd_busy   <= 1'b1;
                col_cnt    <= '0;
                flush_pend <= 1'b0;
                if (col_full) rd <= rd + RD_W'(do_inv ? -disp_i : disp_i);
            end else if (snd_busy) begin
                if (snd_slot == snd_cnt) snd_busy <= 1'b0;
                else                     snd_slot <= snd_slot + 1'b1;
            end
            if (sfd) rd <= '0;
        end
    end

    AST_TX_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (taken && !coding) |=> (out_q.valid && out_q.data == $past(in_bit))); // R2
    AST_MARKER_FIRST: assert property (@(posedge clk) disable iff (rst)
        (snd_busy && snd_slot == '0) |=> (out_q.valid && out_q.data == $past(snd_inv))); // R3
    AST_PARTIAL_TRUE: assert property (@(posedge clk) disable iff (rst)
        (xfer && !col_full) |=> !snd_inv); // R5
    AST_RD_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (int'(rd) <= BLK) && (int'(rd) >= -BLK)); // R4
    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (coding && col_full) |-> !in_ready); // R6

endmodule

// File: rtl/dcb_rx_dec.sv
module dcb_rx_dec
    import dcb_pkg::*;
#(
    parameter int BLK = BLK_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sfd,
    input  logic  coding,
    input  logic  in_valid,
    input  logic  in_bit,
    output sbit_t out_q
);
    localparam int CW = $clog2(BLK + 1);

    logic [CW-1:0] slot;
    logic          inv;
    sbit_t         emit;

    always_comb begin
        emit = '0;
        if (in_valid) begin
            if (!coding) begin
                emit.valid = 1'b1;
                emit.data  = in_bit;
            end else if (slot != '0) begin
                emit.valid = 1'b1;
                emit.data  = in_bit ^ inv;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            slot  <= '0;
            inv   <= 1'b0;
        end else begin
            out_q <= emit;
            if (sfd || !coding) begin
                slot <= '0;
            end else if (in_valid) begin
                if (slot == '0) begin
                    inv  <= in_bit;
                    slot <= CW'(1);
                end else begin
                    slot <= (slot == CW'(BLK)) ? '0 : slot + 1'b1;
                end
            end
        end
    end

    AST_RX_MARKER_DROP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && coding && slot == '0) |=> !out_q.valid); // R8
    AST_RX_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !coding) |=> (out_q.valid && out_q.data == $past(in_bit))); // R9
    AST_RX_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        slot <= CW'(BLK)); // R8

endmodule

// File: rtl/dcb_codec.sv
module dcb_codec #(
    parameter int BLK   = dcb_pkg::BLK_DEF,
    parameter int OFS_W = dcb_pkg::OFS_W_DEF,
    parameter int RD_W  = dcb_pkg::RD_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_code_en,
    input  logic             rx_code_en,
    input  logic             start_dly_en,
    input  logic [OFS_W-1:0] start_bytes,
    input  logic             tx_sfd,
    input  logic             tx_in_valid,
    input  logic             tx_in_bit,
    input  logic             tx_in_last,
    output logic             tx_in_ready,
    output logic             tx_out_valid,
    output logic             tx_out_bit,
    input  logic             rx_sfd,
    input  logic             rx_in_valid,
    input  logic             rx_in_bit,
    input  logic             rx_in_last,
    output logic             rx_out_valid,
    output logic             rx_out_bit
);
    import dcb_pkg::*;

    logic  tx_coding, rx_coding, tx_taken;
    sbit_t tx_o, rx_o;

    dcb_start_gate #(.OFS_W(OFS_W)) u_tx_gate (
        .clk(clk), .rst(rst), .sfd(tx_sfd), .code_en(tx_code_en),
        .dly_en(start_dly_en), .ofs_bytes(start_bytes),
        .bit_taken(tx_taken), .bit_last(tx_in_last), .coding(tx_coding)
    );

    dcb_start_gate #(.OFS_W(OFS_W)) u_rx_gate (
        .clk(clk), .rst(rst), .sfd(rx_sfd), .code_en(rx_code_en),
        .dly_en(start_dly_en), .ofs_bytes(start_bytes),
        .bit_taken(rx_in_valid), .bit_last(rx_in_last), .coding(rx_coding)
    );

    dcb_tx_enc #(.BLK(BLK), .RD_W(RD_W)) u_tx (
        .clk(clk), .rst(rst), .sfd(tx_sfd), .coding(tx_coding),
        .in_valid(tx_in_valid), .in_bit(tx_in_bit), .in_last(tx_in_last),
        .in_ready(tx_in_ready), .taken(tx_taken), .out_q(tx_o)
    );

    dcb_rx_dec #(.BLK(BLK)) u_rx (
        .clk(clk), .rst(rst), .sfd(rx_sfd), .coding(rx_coding),
        .in_valid(rx_in_valid), .in_bit(rx_in_bit), .out_q(rx_o)
    );

    assign tx_out_valid = tx_o.valid;
    assign tx_out_bit   = tx_o.data;
    assign rx_out_valid = rx_o.valid;
    assign rx_out_bit   = rx_o.data;

endmodule

// File: tb/dcb_codec_bench.sv
`timescale 1ns/1ps
module dcb_codec_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_code_en = 1'b0, rx_code_en = 1'b0, start_dly_en = 1'b0;
    logic [3:0] start_bytes = 4'd0;
    logic       tx_sfd = 1'b0, tx_in_valid = 1'b0, tx_in_bit = 1'b0, tx_in_last = 1'b0;
    logic       rx_sfd = 1'b0, rx_in_valid = 1'b0, rx_in_bit = 1'b0, rx_in_last = 1'b0;
    logic       tx_in_ready, tx_out_valid, tx_out_bit, rx_out_valid, rx_out_bit;

    dcb_codec u_dcb_codec (
        .clk(clk), .rst(rst), .tx_code_en(tx_code_en), .rx_code_en(rx_code_en),
        .start_dly_en(start_dly_en), .start_bytes(start_bytes),
        .tx_sfd(tx_sfd), .tx_in_valid(tx_in_valid), .tx_in_bit(tx_in_bit),
        .tx_in_last(tx_in_last), .tx_in_ready(tx_in_ready),
        .tx_out_valid(tx_out_valid), .tx_out_bit(tx_out_bit),
        .rx_sfd(rx_sfd), .rx_in_valid(rx_in_valid), .rx_in_bit(rx_in_bit),
        .rx_in_last(rx_in_last), .rx_out_valid(rx_out_valid), .rx_out_bit(rx_out_bit)
    );

    always #4 clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    bit in_bits [0:255];
    bit exp_q   [0:511];
    bit cap_tx  [0:511];
    bit cap_rx  [0:511];
    bit rx_src  [0:511];
    int n_in = 0, n_exp = 0, n_tx = 0, n_rx = 0, n_src = 0, stalls = 0;

    always @(negedge clk) begin
        if (tx_out_valid && n_tx < 512) begin cap_tx[n_tx] = tx_out_bit; n_tx++; end
        if (rx_out_valid && n_rx < 512) begin cap_rx[n_rx] = rx_out_bit; n_rx++; end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Expected line stream built from the coding rules.
    task automatic model_tx(input int n, input bit en, input int off);
        int rd = 0;
        int pre;
        n_exp = 0;
        pre = en ? ((off < n) ? off : n) : n;
        for (int i = 0; i < pre; i++) begin exp_q[n_exp] = in_bits[i]; n_exp++; end
        for (int b = pre; b < n; b += 16) begin
            int k = (n - b < 16) ? n - b : 16;
            int pop = 0;
            bit inv = 1'b0;
            for (int j = 0; j < k; j++) pop += int'(in_bits[b+j]);
            if (k == 16) begin
                int d = 2 * pop - 16;
                inv = (rd != 0) && (d != 0) && ((rd < 0) == (d < 0));
                rd += inv ? -d : d;
            end
            exp_q[n_exp] = inv; n_exp++;
            for (int j = 0; j < k; j++) begin exp_q[n_exp] = in_bits[b+j] ^ inv; n_exp++; end
        end
    endtask

    task automatic drive_tx(input int n, input bit with_sfd);
        n_tx = 0; stalls = 0; n_in = n;
        @(negedge clk);
        if (with_sfd) begin
            tx_sfd = 1'b1;
            @(negedge clk);
            tx_sfd = 1'b0;
        end
        for (int i = 0; i < n; ) begin
            tx_in_valid = 1'b1;
            tx_in_bit   = in_bits[i];
            tx_in_last  = with_sfd && (i == n - 1);
            if (tx_in_ready) i++;
            else stalls++;
            @(negedge clk);
        end
        tx_in_valid = 1'b0; tx_in_last = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic drive_rx_from_tx();
        n_src = n_tx;
        for (int i = 0; i < n_tx; i++) rx_src[i] = cap_tx[i];
        n_rx = 0;
        @(negedge clk);
        rx_sfd = 1'b1;
        @(negedge clk);
        rx_sfd = 1'b0;
        for (int i = 0; i < n_src; i++) begin
            rx_in_valid = 1'b1;
            rx_in_bit   = rx_src[i];
            rx_in_last  = (i == n_src - 1);
            @(negedge clk);
        end
        rx_in_valid = 1'b0; rx_in_last = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp_tx(input string req);
        int bad = -1;
        chk(n_tx == n_exp, {req, " tx length"}, n_tx, n_exp);
        for (int i = 0; i < n_exp && i < n_tx; i++)
            if (bad < 0 && cap_tx[i] != exp_q[i]) bad = i;
        chk(bad < 0, {req, " tx stream first bad bit index"}, bad, -1);
    endtask

    // decoded: compare with original bits; raw: compare with receive input stream
    task automatic cmp_rx(input string req, input bit decoded);
        int bad = -1;
        int n_want = decoded ? n_in : n_src;
        chk(n_rx == n_want, {req, " rx length"}, n_rx, n_want);
        for (int i = 0; i < n_want && i < n_rx; i++)
            if (bad < 0 && cap_rx[i] != (decoded ? in_bits[i] : rx_src[i])) bad = i;
        chk(bad < 0, {req, " rx stream first bad bit index"}, bad, -1);
    endtask

    task automatic cfg(input bit txe, input bit rxe, input bit dly, input int bytes);
        tx_code_en = txe; rx_code_en = rxe; start_dly_en = dly; start_bytes = 4'(bytes);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(tx_out_valid == 1'b0, "R1 tx_out_valid", int'(tx_out_valid), 0);
        chk(rx_out_valid == 1'b0, "R1 rx_out_valid", int'(rx_out_valid), 0);
        chk(tx_in_ready == 1'b1, "R1 tx_in_ready", int'(tx_in_ready), 1);
    endtask

    task automatic t_bypass();
        cfg(0, 0, 0, 0);
        for (int i = 0; i < 20; i++) in_bits[i] = ((i % 3) == 0);
        drive_tx(20, 1);
        model_tx(20, 0, 0);
        cmp_tx("R2 disabled frame");
        drive_rx_from_tx();
        cmp_rx("R9 rx disabled", 0);
        for (int i = 0; i < 10; i++) in_bits[i] = ((i % 4) < 2);
        drive_tx(10, 0);
        model_tx(10, 0, 0);
        cmp_tx("R2 outside frame");
    endtask

    task automatic t_blocks();
        cfg(1, 1, 0, 0);
        for (int i = 0; i < 16; i++) in_bits[i] = 1'b1;
        for (int i = 16; i < 32; i++) in_bits[i] = (i % 4) != 0;
        for (int i = 32; i < 40; i++) in_bits[i] = 1'b1;
        drive_tx(40, 1);
        model_tx(40, 1, 0);
        cmp_tx("R3 R4 mixed frame");
        chk(cap_tx[0] == 1'b0, "R3 first marker true", int'(cap_tx[0]), 0);
        chk(cap_tx[17] == 1'b1, "R4 second block inverted", int'(cap_tx[17]), 1);
        chk(cap_tx[34] == 1'b0, "R5 partial marker", int'(cap_tx[34]), 0);
        chk(cap_tx[35] == 1'b1, "R5 partial bit true", int'(cap_tx[35]), 1);
        drive_rx_from_tx();
        cmp_rx("R8 loopback mixed", 1);
        // rx disabled sees the coded stream untouched
        cfg(1, 0, 0, 0);
        drive_rx_from_tx();
        cmp_rx("R9 rx disabled coded", 0);
    endtask

    task automatic t_stall();
        cfg(1, 1, 0, 0);
        for (int i = 0; i < 48; i++) in_bits[i] = (((i * 5) + (i / 3)) % 7) < 3;
        drive_tx(48, 1);
        model_tx(48, 1, 0);
        chk(stalls == 2, "R6 stall cycles", stalls, 2);
        chk(n_tx == 51, "R6 line bits for 3 blocks", n_tx, 51);
        cmp_tx("R6 pattern frame");
        drive_rx_from_tx();
        cmp_rx("R8 loopback pattern", 1);
    endtask

    task automatic t_full_last();
        cfg(1, 1, 0, 0);
        for (int i = 0; i < 32; i++) in_bits[i] = 1'b1;
        drive_tx(32, 1);
        model_tx(32, 1, 0);
        cmp_tx("R5 exact full last block");
        chk(cap_tx[17] == 1'b1, "R5 full last block follows R4", int'(cap_tx[17]), 1);
    endtask

    task automatic t_offset();
        cfg(1, 1, 1, 2);
        for (int i = 0; i < 36; i++) in_bits[i] = (i % 5) < 3;
        drive_tx(36, 1);
        model_tx(36, 1, 16);
        cmp_tx("R7 two byte delay");
        drive_rx_from_tx();
        cmp_rx("R8 delayed start loopback", 1);
        cfg(1, 1, 1, 0);
        for (int i = 0; i < 20; i++) in_bits[i] = (i % 2) == 0;
        drive_tx(20, 1);
        model_tx(20, 1, 0);
        cmp_tx("R7 delay of zero bytes");
        cfg(1, 1, 0, 3);
        drive_tx(20, 1);
        model_tx(20, 1, 0);
        cmp_tx("R7 delay select off ignores byte count");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bypass();
        t_blocks();
        t_stall();
        t_full_last();
        t_offset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule